// File: doc/BRIEF.md
# Narrow-Value ECC Register File

A 64-bit register file with one synchronous write port and two asynchronous read ports, built to ride through clustered soft errors. Every stored word is cut into sixteen 4-bit data groups, and each group carries an extended Hamming (8,4) code of four check bits. That code repairs one flipped bit and flags two. The check bits live in their own array, one 64-bit check word per entry. Within that check word they are spread so that neighbouring positions belong to different groups.

On a write the block decides whether the value fits in 32 bits and records the answer in two status bits per entry. A value that fits is stored twice, once in each 32-bit half, and each copy has its own check bits. On a read, purely combinational logic decodes all groups. A narrow entry picks a healthy copy and sign-extends it. A wide entry repairs each group in place. Each read port reports a corrected-error flag and an uncorrectable-error flag with its data.

Separate injection inputs flip chosen bits of a stored entry so that upsets can be modelled.

Top module: `nv_ecc_regfile`

## Requirements
- R1: While reset is low every entry clears; after reset every address reads data 0 with both flags low.
- R2: A write lands at the rising clock edge. Reads are combinational, so a read of the written address in the same cycle returns the previous contents.
- R3: A value is narrow when its bits 63..31 are all equal. Narrow values get status code 01 and other values get 00. A status code with bit 1 set is read as wide.
- R4: A narrow value is stored in both 32-bit halves. Any burst of 1 to 32 adjacent flipped data bits lying wholly in bits 31..0 or wholly in bits 63..32 still reads back as the original value, with corr=1 and unc=0.
- R5: A narrow entry reads back with unc=1 and corr=0 only when both halves hold a group with a double error. If one half has a double error and the other half has a single error, the single error is corrected.
- R6: For a wide entry, data group i is bits 4i+3..4i. One flipped bit in any data or check position is repaired, with corr=1 and unc=0.
- R7: For a wide entry, two flipped bits inside one data group give unc=1 and corr=0.
- R8: Check bit k of group n sits at position 16k+n of the entry's check word. Any burst of up to 16 adjacent flipped check positions is corrected on wide and narrow entries.
- R9: An entry with no upsets reads with corr=0 and unc=0, and corr and unc are never high together.
- R10: Both read ports can address different entries in the same cycle, and each returns the result for its own address.
- R11: When inj_en is high at a clock edge, the three masks are XORed into the data, check and status of entry inj_addr. A write to the same address in the same cycle overrides the injection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all entries |
| we | input | 1 | Write enable |
| waddr | input | AW | Write address |
| wdata | input | 64 | Write data |
| inj_en | input | 1 | Apply fault masks at the next edge |
| inj_addr | input | AW | Entry to corrupt |
| inj_data | input | 64 | XOR mask for stored data |
| inj_chk | input | 64 | XOR mask for stored check word |
| inj_flag | input | 2 | XOR mask for status bits |
| ra_addr | input | AW | Read port A address |
| ra_data | output | 64 | Port A repaired data |
| ra_corr | output | 1 | Port A error corrected |
| ra_unc | output | 1 | Port A uncorrectable error |
| rb_addr | input | AW | Read port B address |
| rb_data | output | 64 | Port B repaired data |
| rb_corr | output | 1 | Port B error corrected |
| rb_unc | output | 1 | Port B uncorrectable error |

## Verification
The read-back and duplication properties apply only in cycles that follow a write with no injection pending. The hold property expects the read address and the array to stay unchanged. The stimulus drives writes and injections in separate cycles, except in the one deliberate write-beats-injection case. It always rewrites an entry before injecting new faults, so each fault pattern is applied to a clean codeword. Faults are limited to the patterns the requirements promise to handle: in-half bursts, check-word bursts, single flips and double flips within one group.

// File: rtl/nv_ecc_regfile.sv
module nv_ecc_regfile #(
  parameter int AW = 6,
  parameter int W  = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          inj_en,
  input  logic [AW-1:0] inj_addr,
  input  logic [W-1:0]  inj_data,
  input  logic [W-1:0]  inj_chk,
  input  logic [1:0]    inj_flag,
  input  logic [AW-1:0] ra_addr,
  output logic [W-1:0]  ra_data,
  output logic          ra_corr,
  output logic          ra_unc,
  input  logic [AW-1:0] rb_addr,
  output logic [W-1:0]  rb_data,
  output logic          rb_corr,
  output logic          rb_unc
);
  localparam int DEPTH = 1 << AW;
  localparam int NIB   = W / 4;
  localparam int NH    = NIB / 2;
  localparam int H     = W / 2;

  logic [W-1:0] dmem [DEPTH];
  logic [W-1:0] cmem [DEPTH];
  logic [1:0]   fmem [DEPTH];

  // check nibble layout: {p0, p4, p2, p1}
  function automatic logic [3:0] enc4(input logic [3:0] d);
    logic p1, p2, p4;
    p1 = d[0] ^ d[1] ^ d[3];
    p2 = d[0] ^ d[2] ^ d[3];
    p4 = d[1] ^ d[2] ^ d[3];
    return {^{p1, p2, p4, d}, p4, p2, p1};
  endfunction

  function automatic logic [W-1:0] enc_word(input logic [W-1:0] d);
    logic [W-1:0] cw;
    logic [3:0] c;
    cw = '0;
    for (int n = 0; n < NIB; n++) begin
      c = enc4(d[4*n +: 4]);
      for (int k = 0; k < 4; k++) cw[k*NIB + n] = c[k];
    end
    return cw;
  endfunction

  // returns {fixed data, single, double}
  function automatic logic [5:0] dec4(input logic [3:0] d, input logic [3:0] c);
    logic [2:0] s;
    logic ov;
    logic [3:0] f;
    s[0] = c[0] ^ d[0] ^ d[1] ^ d[3];
    s[1] = c[1] ^ d[0] ^ d[2] ^ d[3];
    s[2] = c[2] ^ d[1] ^ d[2] ^ d[3];
    ov = ^{c, d};
    f = d;
    if (ov) begin
      case (s)
        3'd3: f[0] = ~d[0];
        3'd5: f[1] = ~d[1];
        3'd6: f[2] = ~d[2];
        3'd7: f[3] = ~d[3];
        default: ;
      endcase
    end
    return {f, ov, !ov && (s != 3'd0)};
  endfunction

  function automatic logic [W+1:0] rd_word(input logic [W-1:0] d, input logic [W-1:0] cw,
                                           input logic [1:0] fl);
    logic [W-1:0] fix, val;
    logic [NIB-1:0] sgl, dbl;
    logic [5:0] r;
    logic [3:0] c;
    logic lo_any, hi_any, lo_dbl, hi_dbl, unc;
    for (int n = 0; n < NIB; n++) begin
      for (int k = 0; k < 4; k++) c[k] = cw[k*NIB + n];
      r = dec4(d[4*n +: 4], c);
      fix[4*n +: 4] = r[5:2];
      sgl[n] = r[1];
      dbl[n] = r[0];
    end
    lo_any = |(sgl[NH-1:0] | dbl[NH-1:0]);
    hi_any = |(sgl[NIB-1:NH] | dbl[NIB-1:NH]);
    lo_dbl = |dbl[NH-1:0];
    hi_dbl = |dbl[NIB-1:NH];
    if (fl == 2'b01) begin
      unc = lo_dbl && hi_dbl;
      if (!lo_any || (hi_any && !lo_dbl))
        val = {{H{fix[H-1]}}, fix[H-1:0]};
      else
        val = {{H{fix[W-1]}}, fix[W-1:H]};
    end else begin
      unc = |dbl;
      val = fix;
    end
    return {val, (lo_any || hi_any) && !unc, unc};
  endfunction

  logic         nw;
  logic [W-1:0] sw;
  assign nw = (&wdata[W-1:H-1]) | ~(|wdata[W-1:H-1]);
  assign sw = nw ? {2{wdata[H-1:0]}} : wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        dmem[i] <= '0;
        cmem[i] <= '0;
        fmem[i] <= 2'b00;
      end
    end else begin
      if (inj_en) begin
        dmem[inj_addr] <= dmem[inj_addr] ^ inj_data;
        cmem[inj_addr] <= cmem[inj_addr] ^ inj_chk;
        fmem[inj_addr] <= fmem[inj_addr] ^ inj_flag;
      end
      if (we) begin
        dmem[waddr] <= sw;
        cmem[waddr] <= enc_word(sw);
        fmem[waddr] <= {1'b0, nw};
      end
    end
  end

  assign {ra_data, ra_corr, ra_unc} = rd_word(dmem[ra_addr], cmem[ra_addr], fmem[ra_addr]);
  assign {rb_data, rb_corr, rb_unc} = rd_word(dmem[rb_addr], cmem[rb_addr], fmem[rb_addr]);

  p_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(we) && !$past(inj_en) && ra_addr == $past(waddr)
    |-> ra_data == $past(wdata) && !ra_corr && !ra_unc);

  p_dup_halves_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(we) && !$past(inj_en) && ra_addr == $past(waddr) && fmem[ra_addr] == 2'b01
    |-> dmem[ra_addr][W-1:H] == dmem[ra_addr][H-1:0]);

  p_flag_excl_a_r9: assert property (@(posedge clk) disable iff (!rst_n) !(ra_corr && ra_unc));
  p_flag_excl_b_r9: assert property (@(posedge clk) disable iff (!rst_n) !(rb_corr && rb_unc));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(we) && !$past(inj_en) && $stable(rb_addr)
    |-> $stable(rb_data) && $stable(rb_corr) && $stable(rb_unc));
endmodule

// File: tb/nv_ecc_regfile_bench.sv
module nv_ecc_regfile_bench;
  localparam int AW = 4;
  logic clk = 0, rst_n = 0, we = 0, inj_en = 0;
  logic [AW-1:0] waddr = '0, inj_addr = '0, ra_addr = '0, rb_addr = '0;
  logic [63:0] wdata = '0, inj_data = '0, inj_chk = '0, ra_data, rb_data;
  logic [1:0] inj_flag = '0;
  logic ra_corr, ra_unc, rb_corr, rb_unc;
  int checks = 0, errors = 0;

  nv_ecc_regfile #(.AW(AW), .W(64)) u_nv_ecc_regfile (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
    .inj_en(inj_en), .inj_addr(inj_addr), .inj_data(inj_data), .inj_chk(inj_chk),
    .inj_flag(inj_flag), .ra_addr(ra_addr), .ra_data(ra_data), .ra_corr(ra_corr),
    .ra_unc(ra_unc), .rb_addr(rb_addr), .rb_data(rb_data), .rb_corr(rb_corr), .rb_unc(rb_unc));

  always #2 clk = ~clk;

  function automatic logic is_narrow(input logic [63:0] v);
    return v == {{32{v[31]}}, v[31:0]};
  endfunction

  task automatic check(input string tag, input logic [63:0] gd, input logic [63:0] ed, input logic cd,
                       input logic gc, input logic ec, input logic gu, input logic eu);
    checks++;
    if ((cd && gd !== ed) || gc !== ec || gu !== eu) begin
      errors++;
      $display("FAIL %s: data=%h corr=%0b unc=%0b, expected data=%h corr=%0b unc=%0b",
               tag, gd, gc, gu, ed, ec, eu);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [63:0] v);
    @(negedge clk); we = 1; waddr = a; wdata = v;
    @(negedge clk); we = 0;
  endtask

  task automatic inj(input logic [AW-1:0] a, input logic [63:0] dm, input logic [63:0] cm,
                     input logic [1:0] fm);
    @(negedge clk); inj_en = 1; inj_addr = a; inj_data = dm; inj_chk = cm; inj_flag = fm;
    @(negedge clk); inj_en = 0; inj_data = '0; inj_chk = '0; inj_flag = '0;
  endtask

  task automatic rda(input string tag, input logic [AW-1:0] a, input logic [63:0] ed, input logic cd,
                     input logic ec, input logic eu);
    ra_addr = a; #1;
    check(tag, ra_data, ed, cd, ra_corr, ec, ra_unc, eu);
  endtask

  localparam logic [63:0] WIDE = 64'hA5C3_1E2D_7B69_F084;
  localparam logic [63:0] NPOS = 64'h0000_0000_5A3C_96E1;
  localparam logic [63:0] NNEG = 64'hFFFF_FFFF_9C4B_2E17;

  initial begin
    logic [63:0] vals [8];
    vals[0] = 64'h0000_0000_7FFF_FFFF; vals[1] = 64'h0000_0000_8000_0000;
    vals[2] = 64'hFFFF_FFFF_8000_0000; vals[3] = 64'hFFFF_FFFF_7FFF_FFFF;
    vals[4] = 64'hFFFF_FFFF_FFFF_FFFF; vals[5] = WIDE;
    vals[6] = NPOS;                     vals[7] = 64'h8000_0000_0000_0001;

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state on both ports
    for (int a = 0; a < 16; a++) begin
      ra_addr = AW'(a); rb_addr = AW'(15 - a); #1;
      check("R1 port a", ra_data, 64'd0, 1, ra_corr, 0, ra_unc, 0);
      check("R1 port b", rb_data, 64'd0, 1, rb_corr, 0, rb_unc, 0);
    end

    // R2/R9/R10 clean write and read back on both ports
    for (int i = 0; i < 8; i++) wr(AW'(i), vals[i]);
    for (int i = 0; i < 8; i++) begin
      ra_addr = AW'(i); rb_addr = AW'(7 - i); #1;
      check("R2 R9 port a", ra_data, vals[i], 1, ra_corr, 0, ra_unc, 0);
      check("R10 port b", rb_data, vals[7 - i], 1, rb_corr, 0, rb_unc, 0);
    end

    // R2 same-cycle read sees old contents
    wr(5, 64'h1111_2222_3333_4444);
    @(negedge clk); we = 1; waddr = 5; wdata = 64'h5555_6666_7777_8888; ra_addr = 5; #1;
    check("R2 old value", ra_data, 64'h1111_2222_3333_4444, 1, ra_corr, 0, ra_unc, 0);
    @(negedge clk); we = 0; #1;
    check("R2 new value", ra_data, 64'h5555_6666_7777_8888, 1, ra_corr, 0, ra_unc, 0);

    // R3 classification observed through a full low-half burst
    for (int i = 0; i < 8; i++) begin
      wr(3, vals[i]);
      inj(3, 64'h0000_0000_FFFF_FFFF, 64'd0, 2'b00);
      if (is_narrow(vals[i])) rda("R3 narrow", 3, vals[i], 1, 1, 0);
      else rda("R3 wide", 3, 64'd0, 0, 0, 1);
    end
    // R3 reserved status code reads as wide
    wr(4, NPOS);
    inj(4, 64'd0, 64'd0, 2'b10);
    rda("R3 reserved clean", 4, {NPOS[31:0], NPOS[31:0]}, 1, 0, 0);
    inj(4, 64'h3, 64'd0, 2'b00);
    rda("R3 reserved as wide", 4, 64'd0, 0, 0, 1);

    // R4 every burst inside one half of a narrow entry
    for (int h = 0; h < 2; h++)
      for (int len = 1; len <= 32; len++)
        for (int s = 0; s + len <= 32; s++) begin
          logic [63:0] v, m;
          v = ((len + s) % 2 == 1) ? NNEG : NPOS;
          m = (((64'd1 << len) - 64'd1) << s) << (32 * h);
          wr(2, v);
          inj(2, m, 64'd0, 2'b00);
          rda("R4 half burst", 2, v, 1, 1, 0);
        end

    // R5 both copies double vs one double plus one single
    wr(6, NNEG);
    inj(6, 64'h0000_0003_0000_0003, 64'd0, 2'b00);
    rda("R5 both double", 6, 64'd0, 0, 0, 1);
    wr(6, NNEG);
    inj(6, 64'h0000_0010_0000_0003, 64'd0, 2'b00);
    rda("R5 high single used", 6, NNEG, 1, 1, 0);
    wr(6, NPOS);
    inj(6, 64'h0000_0003_0000_0100, 64'd0, 2'b00);
    rda("R5 low single used", 6, NPOS, 1, 1, 0);

    // R6 single flips on a wide entry, every data and check position
    for (int b = 0; b < 64; b++) begin
      wr(7, WIDE);
      inj(7, 64'd1 << b, 64'd0, 2'b00);
      rda("R6 data flip", 7, WIDE, 1, 1, 0);
      wr(7, WIDE);
      inj(7, 64'd0, 64'd1 << b, 2'b00);
      rda("R6 check flip", 7, WIDE, 1, 1, 0);
    end

    // R7 every pair of flips inside one group of a wide entry
    for (int n = 0; n < 16; n++)
      for (int a = 0; a < 4; a++)
        for (int b = a + 1; b < 4; b++) begin
          wr(8, WIDE);
          inj(8, (64'd1 << (4 * n + a)) | (64'd1 << (4 * n + b)), 64'd0, 2'b00);
          rda("R7 double in group", 8, 64'd0, 0, 0, 1);
        end

    // R8 check-word bursts up to 16 positions
    for (int s = 0; s <= 48; s++) begin
      wr(9, WIDE);
      inj(9, 64'd0, 64'hFFFF << s, 2'b00);
      rda("R8 wide check burst", 9, WIDE, 1, 1, 0);
      wr(9, NNEG);
      inj(9, 64'd0, 64'hFFFF << s, 2'b00);
      rda("R8 narrow check burst", 9, NNEG, 1, 1, 0);
    end
    for (int len = 1; len <= 16; len++) begin
      wr(10, WIDE);
      inj(10, 64'd0, ((64'd1 << len) - 64'd1) << 40, 2'b00);
      rda("R8 short check burst", 10, WIDE, 1, 1, 0);
    end

    // R11 injection persists, and write wins on a shared address
    wr(11, WIDE);
    inj(11, 64'h3, 64'd0, 2'b00);
    rda("R11 injection applied", 11, 64'd0, 0, 0, 1);
    @(negedge clk); we = 1; waddr = 11; wdata = WIDE;
    inj_en = 1; inj_addr = 11; inj_data = 64'h30; inj_chk = 64'h1; inj_flag = 2'b11;
    @(negedge clk); we = 0; inj_en = 0; inj_data = '0; inj_chk = '0; inj_flag = '0;
    rda("R11 write overrides", 11, WIDE, 1, 0, 0);
    rb_addr = 0; #1;
    check("R10 port b untouched", rb_data, vals[0], 1, rb_corr, 0, rb_unc, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule